// File: doc/BRIEF.md
# Batched Translation-Invalidate Sequence Guard

This block sits where decoded instructions leave decode and where instructions retire. It watches three special instructions that software uses to invalidate address-translation entries in a batch: an opening fence, a per-entry invalidate that names a virtual address, and a closing fence. At decode it marks each of these as illegal or as needing a pipeline flush, depending on one enable bit of a machine-mode control register. At retire it follows the opening/invalidate/closing order across commits. It reports whether a batch is open and raises a one-cycle error when the order is broken.

An instruction that retires with an exception never changes the tracked state. When the enable bit is clear, retirement of these instructions is ignored. A pipeline flush removes the decode-side result of the slot it hits. It does not close an open batch. All outputs are registered, so each one reflects the inputs of the previous clock cycle.

Top module: `inval_seq_guard`

## Requirements
- R1: The instruction kind is a 2-bit code: 00 any other instruction, 01 opening fence, 10 invalidate, 11 closing fence. With the feature enabled, a valid decode of 01 or 11 raises `dec_flush_pipe` one cycle later and does not raise `dec_illegal`. Codes 10 and 00 do not raise `dec_flush_pipe`.
- R2: With the feature disabled, a valid decode of 01, 10 or 11 raises `dec_illegal` one cycle later and never raises `dec_flush_pipe`. Code 00 raises neither.
- R3: With the feature enabled, a valid decode of 10 raises `dec_rs2_reg` one cycle later, meaning the second operand is read from a register and never from an immediate. No other case raises it.
- R4: The feature is enabled exactly when bit 1 of `ctrl_csr` is set. No other bit of `ctrl_csr` has any effect.
- R5: An opening fence that retires with the feature enabled and no exception sets `in_seq` one cycle later.
- R6: A closing fence that retires with the feature enabled and no exception clears `in_seq` one cycle later.
- R7: An invalidate that retires with the feature enabled and no exception while `in_seq` is clear raises `order_err` for one cycle.
- R8: An opening fence that retires while `in_seq` is already set raises `order_err`, and `in_seq` stays set.
- R9: A closing fence that retires while `in_seq` is clear raises `order_err`, and `in_seq` stays clear.
- R10: A retirement with `cmt_exc` set changes nothing: `in_seq` holds, and `order_err` and `cmt_flush` stay low.
- R11: An opening or closing fence that retires with the feature enabled and no exception raises `cmt_flush` for one cycle. An invalidate does not.
- R12: `pipe_flush` forces all three decode outputs low one cycle later and leaves `in_seq` unchanged.
- R13: With the feature disabled, retirements leave `in_seq` unchanged and raise neither `order_err` nor `cmt_flush`.
- R14: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_csr | input | CSR_W | Machine-mode control register; bit EN_BIT (default 1) enables the feature |
| pipe_flush | input | 1 | Pipeline flush; squashes the decode slot |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_kind | input | 2 | Kind code of the decoded instruction |
| cmt_valid | input | 1 | An instruction retires this cycle |
| cmt_kind | input | 2 | Kind code of the retiring instruction |
| cmt_exc | input | 1 | The retiring instruction takes an exception |
| dec_illegal | output | 1 | Decoded instruction raises illegal-instruction |
| dec_flush_pipe | output | 1 | Decoded instruction needs a flush after it |
| dec_rs2_reg | output | 1 | Second operand comes from a register |
| in_seq | output | 1 | An invalidation batch is open |
| order_err | output | 1 | Ordering violation pulse |
| cmt_flush | output | 1 | Flush request from a retiring fence |

## Verification
Legal batches are driven first: one with no invalidates, one with several, and two batches back to back. These show that the open flag follows the fences and that no error appears. Each wrong order is then driven on its own: a stray invalidate, a repeated opening fence and an orphan closing fence. Each must raise the error while the flag keeps the value that requirement gives. The same kinds are repeated with the enable bit clear, with only other bits of the control register set, with exceptions on retirement, and with a flush on the decode slot. These runs separate the effect of gating from the effect of the order rules.

// File: rtl/inval_seq_pkg.sv
package inval_seq_pkg;

    typedef enum logic [1:0] {
        KIND_OTHER = 2'b00,
        KIND_OPEN  = 2'b01,
        KIND_INVAL = 2'b10,
        KIND_CLOSE = 2'b11
    } inv_kind_e;

    typedef struct packed {
        logic illegal;
        logic flush_pipe;
        logic rs2_reg;
    } dec_res_t;

    typedef struct packed {
        logic open;
        logic err;
        logic flush;
    } cmt_res_t;

endpackage

// File: rtl/inval_feat_enable.sv
module inval_feat_enable #(
    parameter int CSR_W  = 64,
    parameter int EN_BIT = 1
) (
    input  logic [CSR_W-1:0] ctrl_csr,
    output logic             feat_en
);
    // Only one bit matters; fold the rest so every bit has a reader.
    logic csr_unused_fold;
    assign csr_unused_fold = ^ctrl_csr;

    generate
        if (EN_BIT < CSR_W) begin : g_bit_in_range
            assign feat_en = ctrl_csr[EN_BIT];
        end else begin : g_bit_out_of_range
            assign feat_en = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/inval_dec_stage.sv
module inval_dec_stage
    import inval_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       feat_en,
    input  logic       pipe_flush,
    input  logic       dec_valid,
    input  logic [1:0] dec_kind,
    output dec_res_t   res
);
    dec_res_t  res_d, res_q;
    inv_kind_e kind;
    logic      live, special, fence;

    always_comb begin
        kind    = inv_kind_e'(dec_kind);
        live    = dec_valid && !pipe_flush;
        special = (kind != KIND_OTHER);
        fence   = (kind == KIND_OPEN) || (kind == KIND_CLOSE);
        res_d   = '0;
        if (live && special) begin
            if (!feat_en) begin
                res_d.illegal = 1'b1;
            end else begin
                res_d.flush_pipe = fence;
                res_d.rs2_reg    = (kind == KIND_INVAL);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res = res_q;

    // R2: an illegal slot never asks for a flush
    a_r2_illegal_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.illegal |-> !res_q.flush_pipe);
    // R12: a squashed slot yields nothing
    a_r12_flush_squash: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |=> (res_q == '0));
    // R2: disabled feature gives no flush mark
    a_r2_disabled_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_en |=> !res_q.flush_pipe && !res_q.rs2_reg);
    // R3: register-operand mark only for the invalidate code
    a_r3_rs2_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind != 2'b10) |=> !res_q.rs2_reg);
endmodule

// File: rtl/inval_cmt_tracker.sv
module inval_cmt_tracker
    import inval_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       feat_en,
    input  logic       cmt_valid,
    input  logic [1:0] cmt_kind,
    input  logic       cmt_exc,
    output cmt_res_t   res
);
    cmt_res_t  st_d, st_q;
    inv_kind_e kind;
    logic      act;

    always_comb begin
        kind      = inv_kind_e'(cmt_kind);
        act       = cmt_valid && !cmt_exc && feat_en;
        st_d      = st_q;
        st_d.err  = 1'b0;
        st_d.flush = 1'b0;
        if (act) begin
            unique case (kind)
                KIND_OPEN: begin
                    st_d.err   = st_q.open;
                    st_d.open  = 1'b1;
                    st_d.flush = 1'b1;
                end
                KIND_INVAL: begin
                    st_d.err = !st_q.open;
                end
                KIND_CLOSE: begin
                    st_d.err   = !st_q.open;
                    st_d.open  = 1'b0;
                    st_d.flush = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res = st_q;

    // R5: the open flag only rises after a clean opening fence
    a_r5_open_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.open) |-> $past(cmt_valid && !cmt_exc && feat_en && cmt_kind == 2'b01));
    // R10: an excepting retirement leaves all state alone
    a_r10_exc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_exc) |=> $stable(st_q.open) && !st_q.err && !st_q.flush);
    // R13: nothing moves while the feature is disabled
    a_r13_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_en |=> $stable(st_q.open) && !st_q.err && !st_q.flush);
    // R7: an error pulse always follows a retirement
    a_r7_err_has_cmt: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> $past(cmt_valid));
    // R11: invalidate never asks for a retire flush
    a_r11_inval_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_kind == 2'b10) |=> !st_q.flush);
endmodule

// File: rtl/inval_seq_guard.sv
module inval_seq_guard
    import inval_seq_pkg::*;
#(
    parameter int CSR_W  = 64,
    parameter int EN_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CSR_W-1:0] ctrl_csr,
    input  logic             pipe_flush,
    input  logic             dec_valid,
    input  logic [1:0]       dec_kind,
    input  logic             cmt_valid,
    input  logic [1:0]       cmt_kind,
    input  logic             cmt_exc,
    output logic             dec_illegal,
    output logic             dec_flush_pipe,
    output logic             dec_rs2_reg,
    output logic             in_seq,
    output logic             order_err,
    output logic             cmt_flush
);
    logic     feat_en;
    dec_res_t dec_res;
    cmt_res_t cmt_res;

    inval_feat_enable #(.CSR_W(CSR_W), .EN_BIT(EN_BIT)) u_enable (
        .ctrl_csr (ctrl_csr),
        .feat_en  (feat_en)
    );

    inval_dec_stage u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .feat_en    (feat_en),
        .pipe_flush (pipe_flush),
        .dec_valid  (dec_valid),
        .dec_kind   (dec_kind),
        .res        (dec_res)
    );

    inval_cmt_tracker u_cmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .feat_en   (feat_en),
        .cmt_valid (cmt_valid),
        .cmt_kind  (cmt_kind),
        .cmt_exc   (cmt_exc),
        .res       (cmt_res)
    );

    assign dec_illegal    = dec_res.illegal;
    assign dec_flush_pipe = dec_res.flush_pipe;
    assign dec_rs2_reg    = dec_res.rs2_reg;
    assign in_seq         = cmt_res.open;
    assign order_err      = cmt_res.err;
    assign cmt_flush      = cmt_res.flush;

    // R12: a decode flush never touches the batch flag
    a_r12_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_flush && !cmt_valid) |=> $stable(in_seq));
endmodule

// File: tb/test_inval_seq_guard.sv
module test_inval_seq_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] ctrl_csr;
    logic        pipe_flush, dec_valid, cmt_valid, cmt_exc;
    logic [1:0]  dec_kind, cmt_kind;
    logic        dec_illegal, dec_flush_pipe, dec_rs2_reg, in_seq, order_err, cmt_flush;

    always #4 clk = ~clk;

    inval_seq_guard i_inval_seq_guard (
        .clk(clk), .rst_n(rst_n), .ctrl_csr(ctrl_csr), .pipe_flush(pipe_flush),
        .dec_valid(dec_valid), .dec_kind(dec_kind), .cmt_valid(cmt_valid),
        .cmt_kind(cmt_kind), .cmt_exc(cmt_exc), .dec_illegal(dec_illegal),
        .dec_flush_pipe(dec_flush_pipe), .dec_rs2_reg(dec_rs2_reg), .in_seq(in_seq),
        .order_err(order_err), .cmt_flush(cmt_flush)
    );

    typedef struct {
        logic [5:0] outs;
        string      tag;
    } exp_t;

    exp_t queue_q[$];
    int   checks = 0;
    int   errors = 0;
    logic m_open = 1'b0;
    bit   done = 1'b0;

    localparam logic [63:0] EN  = 64'h2;
    localparam logic [63:0] DIS = 64'h0;
    localparam logic [63:0] OTH = 64'hFFFF_FFFF_FFFF_FFFD;

    task automatic check6(input logic [5:0] act, input logic [5:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (illegal,dflush,rs2,in_seq,err,cflush)",
                     tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(input logic [63:0] csr, input logic dv, input logic [1:0] dk,
                        input logic pf, input logic cv, input logic [1:0] ck,
                        input logic ce, input string tag);
        logic en, live, act, e_ill, e_df, e_rs, e_err, e_cf;
        @(negedge clk);
        ctrl_csr = csr; dec_valid = dv; dec_kind = dk; pipe_flush = pf;
        cmt_valid = cv; cmt_kind = ck; cmt_exc = ce;
        en    = csr[1];
        live  = dv && !pf && dk != 2'b00;
        e_ill = live && !en;
        e_df  = live && en && (dk == 2'b01 || dk == 2'b11);
        e_rs  = live && en && dk == 2'b10;
        act   = cv && !ce && en && ck != 2'b00;
        e_err = act && ((ck == 2'b01 && m_open) || (ck == 2'b10 && !m_open) ||
                        (ck == 2'b11 && !m_open));
        e_cf  = act && (ck == 2'b01 || ck == 2'b11);
        if (act && ck == 2'b01) m_open = 1'b1;
        if (act && ck == 2'b11) m_open = 1'b0;
        queue_q.push_back('{outs: {e_ill, e_df, e_rs, m_open, e_err, e_cf}, tag: tag});
    endtask

    task automatic idle(input string tag);
        step(EN, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, tag);
    endtask

    // monitor: compares each queued item after the edge that produced it
    always begin
        @(posedge clk);
        #2;
        if (rst_n && queue_q.size() > 0) begin
            exp_t it;
            it = queue_q.pop_front();
            check6({dec_illegal, dec_flush_pipe, dec_rs2_reg, in_seq, order_err, cmt_flush},
                   it.outs, it.tag);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ctrl_csr = '0; pipe_flush = 0; dec_valid = 0; dec_kind = 0;
        cmt_valid = 0; cmt_kind = 0; cmt_exc = 0;
        repeat (3) @(posedge clk);
        #2;
        check6({dec_illegal, dec_flush_pipe, dec_rs2_reg, in_seq, order_err, cmt_flush},
               6'b0, "R14 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R3 decode, enabled
        step(EN,  1, 2'b01, 0, 0, 2'b00, 0, "R1 open decode");
        step(EN,  1, 2'b10, 0, 0, 2'b00, 0, "R3 inval decode");
        step(EN,  1, 2'b11, 0, 0, 2'b00, 0, "R1 close decode");
        step(EN,  1, 2'b00, 0, 0, 2'b00, 0, "R1 other decode");
        // R2 decode, disabled
        step(DIS, 1, 2'b01, 0, 0, 2'b00, 0, "R2 open illegal");
        step(DIS, 1, 2'b10, 0, 0, 2'b00, 0, "R2 inval illegal");
        step(DIS, 1, 2'b11, 0, 0, 2'b00, 0, "R2 close illegal");
        step(DIS, 1, 2'b00, 0, 0, 2'b00, 0, "R2 other legal");
        // R4 other bits only
        step(OTH, 1, 2'b10, 0, 0, 2'b00, 0, "R4 other bits");
        // R12 decode squash
        step(EN,  1, 2'b01, 1, 0, 2'b00, 0, "R12 squash");
        step(DIS, 1, 2'b11, 1, 0, 2'b00, 0, "R12 squash disabled");

        // legal empty batch: R5 R6 R11
        step(EN, 0, 2'b00, 0, 1, 2'b01, 0, "R5 open commit");
        step(EN, 0, 2'b00, 0, 1, 2'b11, 0, "R6 close commit");
        // batch with invalidates, flush while open
        step(EN, 0, 2'b00, 0, 1, 2'b01, 0, "R5 open again");
        step(EN, 0, 2'b00, 0, 1, 2'b10, 0, "R11 inval no flush");
        step(EN, 1, 2'b10, 1, 1, 2'b10, 0, "R12 flush keeps batch");
        idle("R12 idle open");
        step(EN, 0, 2'b00, 0, 1, 2'b01, 0, "R8 double open");
        step(EN, 0, 2'b00, 0, 1, 2'b11, 1, "R10 close with exc");
        step(EN, 0, 2'b00, 0, 1, 2'b11, 0, "R6 close");
        // errors
        step(EN, 0, 2'b00, 0, 1, 2'b10, 0, "R7 stray inval");
        step(EN, 0, 2'b00, 0, 1, 2'b11, 0, "R9 orphan close");
        step(EN, 0, 2'b00, 0, 1, 2'b01, 1, "R10 open with exc");
        step(EN, 0, 2'b00, 0, 1, 2'b10, 1, "R10 inval with exc");
        // R13 disabled commits
        step(DIS, 0, 2'b00, 0, 1, 2'b01, 0, "R13 disabled open");
        step(OTH, 0, 2'b00, 0, 1, 2'b10, 0, "R13 disabled inval");
        step(EN,  0, 2'b00, 0, 1, 2'b01, 0, "R5 open late");
        step(DIS, 0, 2'b00, 0, 1, 2'b11, 0, "R13 disabled close");
        step(EN,  0, 2'b00, 0, 1, 2'b00, 0, "R13 other commit");
        step(EN,  0, 2'b00, 0, 1, 2'b11, 0, "R6 final close");
        idle("R14 quiet");
        idle("R14 quiet end");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule